// File: doc/BRIEF.md
# Multi-Lane Serial Column Loader

This block loads one row of drive codes for a high-voltage display driver with 320 outputs. Eight serial data pins form four 2-bit lanes. On every shift clock in which the active-low chip select is low, each lane moves one 2-bit code into its own 80-stage chain. A direction input sets which end of each chain takes the new code. Together the four chains hold a full row of 640 bits.

An active-low latch strobe is sampled in the shift clock domain. On its falling edge the whole row is copied into a holding latch. The chains can therefore be refilled while the outputs keep showing the previous row.

A global override stage follows the latch. It either passes each latched code through to its output, or forces all 320 outputs to one common state. The block emits one 2-bit drive code per output. These codes steer the analog output buffers, which are not part of this block.

Top module: `col_loader`

## Requirements
- R1: After reset every chain stage holds 00 and every latch entry holds 11. With `out_en` high and `mode_sel` 00, all outputs read 11 until the first load. A load without any shifting then makes all outputs read 00.
- R2: Lane k takes its data from `lane_data[2k+1:2k]` and fills outputs k*80+1 to k*80+80, numbering outputs from 1. Output j appears on `drive[2j-1:2j-2]`.
- R3: When `dir` is 1 and a shift occurs, the lane's code enters the lowest-numbered stage of that lane, and every other stage takes the value of the stage just below it.
- R4: When `dir` is 0 and a shift occurs, the lane's code enters the highest-numbered stage of that lane, and every other stage takes the value of the stage just above it.
- R5: While `cs_n` is high, no chain stage changes, whatever `lane_data` and `dir` do.
- R6: The latch loads only on a clock edge at which `latch_n` is sampled low after having been sampled high on the previous edge. Holding `latch_n` low, or raising it, leaves the latched row unchanged.
- R7: If a shift and a latch load happen on the same edge, the latch takes the chain contents from before that shift. The shifted contents reach the latch at the next load.
- R8: While `out_en` is low, every output reads 11 (high impedance), whatever `mode_sel` is.
- R9: While `out_en` is high, `mode_sel` 01 forces every output to 00 (ground), 10 forces 01 (medium) and 11 forces 10 (high). The latched data has no effect in these modes.
- R10: While `out_en` is high and `mode_sel` is 00, each output shows its own latched code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low shift enable |
| dir | input | 1 | Fill direction: 1 enters at the low end, 0 at the high end |
| lane_data | input | 8 | Four 2-bit lane codes, lane k on bits 2k+1:2k |
| latch_n | input | 1 | Active-low latch strobe, loads on its falling edge |
| mode_sel | input | 2 | Override select: 00 through, 01 ground, 10 medium, 11 high |
| out_en | input | 1 | Output enable; low forces every output to high impedance |
| drive | output | 640 | Drive codes: 00 ground, 01 medium, 10 high, 11 high impedance |

## Verification
A stage that is stuck, or a lane wired to the wrong slice, does not show at once. The chains stay hidden until the next load. After that load the error shows in pass-through mode as wrong codes in one 80-output group. When the fault is in the direction logic, those codes come out in mirrored order. A latch that reloads while the strobe is held low, or that takes post-shift data, shows one clock after the edge in question. An override decode error shows combinationally, on the same cycle that `mode_sel` or `out_en` changes.

// File: rtl/col_loader_pkg.sv
package col_loader_pkg;

  // Drive code encoding
  localparam logic [1:0] DRV_GND  = 2'b00;
  localparam logic [1:0] DRV_MID  = 2'b01;
  localparam logic [1:0] DRV_HIGH = 2'b10;
  localparam logic [1:0] DRV_HIZ  = 2'b11;

  // Override select codes
  localparam logic [1:0] SEL_THROUGH = 2'b00;
  localparam logic [1:0] SEL_GND     = 2'b01;
  localparam logic [1:0] SEL_MID     = 2'b10;
  localparam logic [1:0] SEL_HIGH    = 2'b11;

  // True when latched codes reach the outputs unchanged
  function automatic logic passes_data(input logic oe, input logic [1:0] sel);
    return oe && (sel == SEL_THROUGH);
  endfunction

  // Common code applied to every output in a forcing mode
  function automatic logic [1:0] forced_code(input logic oe, input logic [1:0] sel);
    logic [1:0] code;
    if (!oe) code = DRV_HIZ;
    else begin
      case (sel)
        SEL_GND:  code = DRV_GND;
        SEL_MID:  code = DRV_MID;
        SEL_HIGH: code = DRV_HIGH;
        default:  code = DRV_HIZ;
      endcase
    end
    return code;
  endfunction

endpackage

// File: rtl/lane_chain.sv
module lane_chain #(
  parameter int STAGES = 80,
  parameter int CW     = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_en,
  input  logic                   dir,
  input  logic [CW-1:0]          din,
  output logic [STAGES*CW-1:0]   stages_o
);

  logic [CW-1:0] stage_q [STAGES];
  logic [CW-1:0] stage_d [STAGES];

  always_comb begin
    stage_d = stage_q;
    if (shift_en) begin
      if (dir) begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
      end else begin
        stage_d[STAGES-1] = din;
        for (int i = 0; i < STAGES-1; i++) stage_d[i] = stage_q[i+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_flat
    assign stages_o[g*CW +: CW] = stage_q[g];
  end

  AST_LOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && dir) |=> (stages_o[CW-1:0] == $past(din))); // R3

  AST_HIGH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !dir) |=> (stages_o[STAGES*CW-1 -: CW] == $past(din))); // R4

  AST_FROZEN_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stages_o)); // R5

endmodule

// File: rtl/strobe_capture.sv
module strobe_capture #(
  parameter int W = 640
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_n,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);

  logic strobe_q;
  logic load_pulse;

  // Falling edge as seen in the shift clock domain
  assign load_pulse = strobe_q & ~strobe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      data_o   <= '1;
    end else begin
      strobe_q <= strobe_n;
      if (load_pulse) data_o <= data_i;
    end
  end

  AST_LOAD_PRESHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> (data_o == $past(data_i))); // R7

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |=> $stable(data_o)); // R6

endmodule

// File: rtl/output_override.sv
module output_override
  import col_loader_pkg::*;
#(
  parameter int OUTS = 320,
  parameter int CW   = 2
) (
  input  logic                 oe,
  input  logic [1:0]           sel,
  input  logic [OUTS*CW-1:0]   latched,
  output logic [OUTS*CW-1:0]   drive
);

  logic          through;
  logic [CW-1:0] common;

  assign through = passes_data(oe, sel);
  assign common  = forced_code(oe, sel);

  for (genvar j = 0; j < OUTS; j++) begin : g_out
    assign drive[j*CW +: CW] = through ? latched[j*CW +: CW] : common;
  end

endmodule

// File: rtl/col_loader.sv
module col_loader #(
  parameter int LANES  = 4,
  parameter int STAGES = 80,
  parameter int CW     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_n,
  input  logic                          dir,
  input  logic [LANES*CW-1:0]           lane_data,
  input  logic                          latch_n,
  input  logic [1:0]                    mode_sel,
  input  logic                          out_en,
  output logic [LANES*STAGES*CW-1:0]    drive
);

  localparam int OUTS      = LANES * STAGES;
  localparam int BITS      = OUTS * CW;
  localparam int LANE_BITS = STAGES * CW;

  logic             shift_en;
  logic [BITS-1:0]  chain_bits;
  logic [BITS-1:0]  latched;

  assign shift_en = ~cs_n;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lane_chain #(.STAGES(STAGES), .CW(CW)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .dir      (dir),
      .din      (lane_data[k*CW +: CW]),
      .stages_o (chain_bits[k*LANE_BITS +: LANE_BITS])
    );
  end

  strobe_capture #(.W(BITS)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (latch_n),
    .data_i   (chain_bits),
    .data_o   (latched)
  );

  output_override #(.OUTS(OUTS), .CW(CW)) u_override (
    .oe      (out_en),
    .sel     (mode_sel),
    .latched (latched),
    .drive   (drive)
  );

  AST_DISABLED_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (drive == {BITS{1'b1}})); // R8

  AST_FORCED_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && mode_sel != 2'b00) |-> (drive == {OUTS{drive[CW-1:0]}})); // R9

  AST_THROUGH_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && mode_sel == 2'b00) |-> (drive == latched)); // R10

endmodule

// File: tb/col_loader_test.sv
module col_loader_test;

  localparam int LANES  = 4;
  localparam int STAGES = 80;
  localparam int OUTS   = LANES * STAGES;
  localparam int BITS   = OUTS * 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cs_n;
  logic            dir;
  logic [7:0]      lane_data;
  logic            latch_n;
  logic [1:0]      mode_sel;
  logic            out_en;
  logic [BITS-1:0] drive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0]      model [OUTS];
  logic [BITS-1:0] held;

  // {out_en, mode_sel, expect_through, forced_code}
  localparam logic [5:0] VEC [0:5] = '{
    6'b1_00_1_00,
    6'b1_01_0_00,
    6'b1_10_0_01,
    6'b1_11_0_10,
    6'b0_00_0_11,
    6'b0_11_0_11
  };

  always #2 clk = ~clk;

  col_loader uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dir(dir), .lane_data(lane_data),
    .latch_n(latch_n), .mode_sel(mode_sel), .out_en(out_en), .drive(drive)
  );

  function automatic logic [BITS-1:0] flat_model();
    logic [BITS-1:0] v;
    for (int j = 0; j < OUTS; j++) v[2*j +: 2] = model[j];
    return v;
  endfunction

  function automatic logic [7:0] pattern(input int t, input int salt);
    return 8'((t * 37 + salt) ^ (t >> 2));
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [BITS-1:0] act, input logic [BITS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Model update for one shift edge (R2, R3, R4)
  task automatic model_shift(input logic d, input logic [7:0] data);
    for (int k = 0; k < LANES; k++) begin
      if (d) begin
        for (int i = STAGES-1; i > 0; i--) model[k*STAGES+i] = model[k*STAGES+i-1];
        model[k*STAGES] = data[2*k +: 2];
      end else begin
        for (int i = 0; i < STAGES-1; i++) model[k*STAGES+i] = model[k*STAGES+i+1];
        model[k*STAGES+STAGES-1] = data[2*k +: 2];
      end
    end
  endtask

  task automatic shift_in(input logic d, input logic [7:0] data);
    cs_n = 1'b0; dir = d; lane_data = data;
    model_shift(d, data);
    tick();
    cs_n = 1'b1;
  endtask

  task automatic pulse_latch();
    latch_n = 1'b0;
    held = flat_model();
    tick();
    latch_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual run still active expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; dir = 1'b1; lane_data = '0;
    latch_n = 1'b1; mode_sel = 2'b00; out_en = 1'b1;
    for (int j = 0; j < OUTS; j++) model[j] = 2'b00;
    @(negedge clk); tick();
    rst_n = 1'b1;
    tick();

    // R1: latch resets to high impedance, chains to ground
    check("R1 reset latch", drive, {BITS{1'b1}});
    pulse_latch();
    check("R1 cleared chain", drive, {BITS{1'b0}});

    // R2 R3: fill low-to-high
    for (int t = 0; t < STAGES; t++) shift_in(1'b1, pattern(t, 11));
    pulse_latch();
    check("R2/R3 dir high fill", drive, held);

    // Override table walk (R8, R9, R10)
    for (int v = 0; v < 6; v++) begin
      out_en = VEC[v][5]; mode_sel = VEC[v][4:3];
      #1;
      if (VEC[v][2]) check("R10 through", drive, held);
      else if (!VEC[v][5]) check("R8 disabled", drive, {OUTS{VEC[v][1:0]}});
      else check("R9 forced", drive, {OUTS{VEC[v][1:0]}});
      @(negedge clk);
    end
    out_en = 1'b1; mode_sel = 2'b00;

    // R5: data and dir toggle with cs_n high
    for (int t = 0; t < 12; t++) begin
      cs_n = 1'b1; dir = t[0]; lane_data = pattern(t, 99);
      tick();
    end
    pulse_latch();
    check("R5 chain frozen", drive, held);

    // R4: fill high-to-low
    for (int t = 0; t < STAGES; t++) shift_in(1'b0, pattern(t, 53));
    pulse_latch();
    check("R4 dir low fill", drive, held);

    // R6: hold strobe low while shifting, then release
    latch_n = 1'b0;
    held = flat_model();
    tick();
    for (int t = 0; t < 5; t++) begin
      cs_n = 1'b0; dir = 1'b0; lane_data = pattern(t, 7);
      model_shift(1'b0, pattern(t, 7));
      tick();
    end
    cs_n = 1'b1;
    check("R6 held low no reload", drive, held);
    latch_n = 1'b1;
    tick();
    check("R6 rising no load", drive, held);

    // R7: shift on the same edge as the load
    latch_n = 1'b0; cs_n = 1'b0; dir = 1'b1; lane_data = 8'hA5;
    held = flat_model();
    model_shift(1'b1, 8'hA5);
    tick();
    cs_n = 1'b1;
    check("R7 pre-shift capture", drive, held);
    latch_n = 1'b1;
    tick();
    pulse_latch();
    check("R7 shifted word next load", drive, held);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule